// File: doc/BRIEF.md
# Pulse-Coded Link Receive Decoder

This block sits on the receive side of a single-bit link that carries level changes as short pulses. A set pulse marks a rising input level and a clear pulse marks a falling one. A bistable state element holds the last level. Between data pulses the transmitter sends periodic refresh pulses, so a healthy link never stays quiet for long.

A starvation counter counts the clock cycles in which no valid pulse arrives. If the gap grows past a programmed limit, the far side is treated as unpowered or broken, and the output is forced to a fail-safe high level. The first valid pulse after that restores the true level at once.

The output pad is modelled as a data bit plus an active-low drive enable. The pad is undriven in three cases: while the block is in reset, while the local power-good input is low, and while the active-high output enable is low. The enable path is registered, so it responds within one clock cycle.

Top module: `pulse_rx_decoder`

## Requirements
- R1: While rst_n is low, and after its release until power-good is sampled high, data_oe_n is 1 and data_out is 0.
- R2: A cycle with set_pls=1 and clr_pls=0 makes data_out 1 after that clock edge. A cycle with set_pls=0 and clr_pls=1 makes it 0. The level is held through cycles with no pulse.
- R3: A cycle with set_pls=1 and clr_pls=1 is invalid. It leaves the held level unchanged and counts as a quiet cycle for the starvation counter.
- R4: With WDOG_CYC quiet cycles between two valid pulses, the output is never forced. At the edge that samples the (WDOG_CYC+1)-th consecutive quiet cycle, the output is forced high.
- R5: While starved and driven, data_out is 1 whatever the held level is. A valid pulse ends the starvation at the same edge that updates the level.
- R6: out_en sampled low makes data_oe_n 1 and data_out 0 after the next edge. out_en sampled high (with power-good high) makes data_oe_n 0 after the next edge.
- R7: While the output is disabled, valid pulses still update the held level, and that level appears as soon as the output is enabled again.
- R8: While pwr_good is sampled low, the output is undriven, the held level returns to 1 and the link counts as starved. When pwr_good rises with out_en high, data_out is driven to 1 until the first valid pulse.
- R9: Valid pulses repeating at intervals shorter than WDOG_CYC cycles never force the output high while the held level is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_good | input | 1 | Output-side supply good |
| out_en | input | 1 | Active-high output enable; tie high when not used |
| set_pls | input | 1 | Set pulse, one cycle wide |
| clr_pls | input | 1 | Clear pulse, one cycle wide |
| data_out | output | 1 | Decoded level (0 when undriven) |
| data_oe_n | output | 1 | Active-low drive enable of the output pad |

## Verification
The bench builds the decoder with WDOG_CYC=20 and a refresh spacing of 10 cycles instead of the default of 500. This makes both sides of the starvation boundary cheap to reach: a gap of exactly 20 quiet cycles and a gap of 21. With the same setting, an invalid double pulse can be placed inside a gap to show that it does not rearm the counter. Enable and power-good transitions are placed while the link is alive and while it is starved, so the fail-safe level and the held level can both be seen after the drive returns.

// File: rtl/pulse_rx_pkg.sv
// Shared types for the pulse-coded link receiver.
// Assumes pulses arrive already synchronised to clk and one cycle wide.
package pulse_rx_pkg;

    typedef enum logic [1:0] {
        PK_NONE = 2'd0,
        PK_SET  = 2'd1,
        PK_CLR  = 2'd2,
        PK_BAD  = 2'd3
    } pulse_kind_e;

    // Sort one sampled cycle into a pulse kind.
    function automatic pulse_kind_e classify(input logic s, input logic c);
        unique case ({s, c})
            2'b10:   return PK_SET;
            2'b01:   return PK_CLR;
            2'b11:   return PK_BAD;
            default: return PK_NONE;
        endcase
    endfunction

    // True for the kinds that carry a level and prove the link is alive.
    function automatic logic is_valid(input pulse_kind_e k);
        return (k == PK_SET) || (k == PK_CLR);
    endfunction

endpackage

// File: rtl/pls_latch.sv
// Bistable level holder. A set pulse stores 1, a clear pulse stores 0, and
// an invalid double pulse is ignored. Returns to the default-high level
// while in reset or while output-side power is not good.
module pls_latch
    import pulse_rx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pwr_good,
    input  pulse_kind_e kind,
    output logic        level
);

    // Update the held level on valid pulses only.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_good)  level <= 1'b1;
        else if (kind == PK_SET)  level <= 1'b1;
        else if (kind == PK_CLR)  level <= 1'b0;
    end

    // R2
    set_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_good && kind == PK_SET) |=> level);

    // R2
    clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_good && kind == PK_CLR) |=> !level);

    // R3
    bad_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_good && kind == PK_BAD) |=> $stable(level));

endmodule

// File: rtl/starve_wdog.sv
// Pulse-starvation timer. It counts consecutive sampled cycles without a
// valid pulse. When one more quiet cycle follows WDOG_CYC of them, it
// raises starved, which stays up until the next valid pulse. The link
// starts out starved after reset and while power is not good.
module starve_wdog
    import pulse_rx_pkg::*;
#(
    parameter int WDOG_CYC = 500
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pwr_good,
    input  pulse_kind_e kind,
    output logic        starved
);

    localparam int CW = $clog2(WDOG_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(WDOG_CYC);

    logic [CW-1:0] quiet_cnt;
    logic          alive;

    assign alive = is_valid(kind);

    // Count quiet cycles; expire when the limit is exceeded.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_good) begin
            quiet_cnt <= '0;
            starved   <= 1'b1;
        end else if (alive) begin
            quiet_cnt <= '0;
            starved   <= 1'b0;
        end else if (!starved) begin
            if (quiet_cnt == LIMIT) starved <= 1'b1;
            else                    quiet_cnt <= quiet_cnt + 1'b1;
        end
    end

    // R5
    pulse_revives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_good && alive) |=> !starved);

    // R4
    quiet_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(starved) |-> (!$past(alive) || !$past(pwr_good)));

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_cnt <= LIMIT);

endmodule

// File: rtl/drive_stage.sv
// Output pad model. It registers the drive enable from power-good and the
// output enable, then presents the fail-safe high level while starved or
// the held level otherwise. An undriven pad reads as 0 on data_out.
module drive_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    input  logic out_en,
    input  logic level,
    input  logic starved,
    output logic data_out,
    output logic data_oe_n
);

    // One-cycle registered drive-enable path.
    always_ff @(posedge clk) begin
        if (!rst_n) data_oe_n <= 1'b1;
        else        data_oe_n <= !(pwr_good && out_en);
    end

    // Select fail-safe or held level onto the pad.
    always_comb begin
        if (data_oe_n)    data_out = 1'b0;
        else if (starved) data_out = 1'b1;
        else              data_out = level;
    end

endmodule

// File: rtl/pulse_rx_decoder.sv
// Receive decoder for a single-bit pulse-coded link: level holder,
// starvation timer with fail-safe high, and an enable-gated output.
// Assumes synchronous, one-cycle-wide set and clear pulses.
module pulse_rx_decoder
    import pulse_rx_pkg::*;
#(
    parameter int WDOG_CYC = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    input  logic out_en,
    input  logic set_pls,
    input  logic clr_pls,
    output logic data_out,
    output logic data_oe_n
);

    pulse_kind_e kind;
    logic        level;
    logic        starved;

    assign kind = classify(set_pls, clr_pls);

    pls_latch u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_good (pwr_good),
        .kind     (kind),
        .level    (level)
    );

    starve_wdog #(.WDOG_CYC(WDOG_CYC)) u_wdog (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_good (pwr_good),
        .kind     (kind),
        .starved  (starved)
    );

    drive_stage u_drv (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_good  (pwr_good),
        .out_en    (out_en),
        .level     (level),
        .starved   (starved),
        .data_out  (data_out),
        .data_oe_n (data_oe_n)
    );

    // R8
    pg_low_undriven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> data_oe_n);

    // R6
    en_low_undriven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |=> (data_oe_n && !data_out));

    // R5
    starve_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (starved && !data_oe_n) |-> data_out);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> data_oe_n);

endmodule

// File: tb/test_pulse_rx_decoder.sv
module test_pulse_rx_decoder;

    localparam int W = 20;

    logic clk = 1'b0;
    logic rst_n, pwr_good, out_en, set_pls, clr_pls;
    logic data_out, data_oe_n;

    always #5 clk = ~clk;

    pulse_rx_decoder #(.WDOG_CYC(W)) i_pulse_rx_decoder (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .out_en(out_en),
        .set_pls(set_pls), .clr_pls(clr_pls),
        .data_out(data_out), .data_oe_n(data_oe_n)
    );

    typedef struct {
        string tag;
        logic  oe_n;
        logic  d;
    } exp_t;

    exp_t q[$];
    int   total = 0;
    int   bad   = 0;

    // requirement model state
    logic m_level, m_dead, m_oe_n;
    int   m_quiet;

    task automatic compare(input string tag, input logic eo, input logic ed);
        total++;
        if (data_oe_n !== eo || data_out !== ed) begin
            bad++;
            $display("FAIL %s: oe_n=%b data=%b expected oe_n=%b data=%b",
                     tag, data_oe_n, data_out, eo, ed);
        end
    endtask

    // Monitor: compare after each edge with the queued expectation.
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            compare(e.tag, e.oe_n, e.d);
        end
    end

    // Driver: apply one cycle of stimulus, advance the model, queue result.
    task automatic step(input logic s, input logic c, input logic e,
                        input logic p, input bit chk, input string tag);
        exp_t x;
        @(negedge clk);
        set_pls = s; clr_pls = c; out_en = e; pwr_good = p;
        if (!p) begin
            m_level = 1'b1; m_dead = 1'b1; m_quiet = 0;
        end else if (s != c) begin
            m_level = s; m_dead = 1'b0; m_quiet = 0;
        end else if (!m_dead) begin
            if (m_quiet == W) m_dead = 1'b1;
            else              m_quiet++;
        end
        m_oe_n = !(p && e);
        x.tag  = tag;
        x.oe_n = m_oe_n;
        x.d    = m_oe_n ? 1'b0 : (m_dead ? 1'b1 : m_level);
        if (chk) q.push_back(x);
    endtask

    initial begin
        #(200000 * 10);
        bad++; total++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; pwr_good = 1'b1; out_en = 1'b1;
        set_pls = 1'b0; clr_pls = 1'b0;
        repeat (3) @(posedge clk);
        #2 compare("R1", 1'b1, 1'b0);
        @(negedge clk);
        rst_n = 1'b1; pwr_good = 1'b0;
        m_level = 1'b1; m_dead = 1'b1; m_oe_n = 1'b1; m_quiet = 0;
        step(0, 0, 1, 0, 1, "R1");

        // power-good rises: driven, fail-safe high
        step(0, 0, 1, 1, 1, "R8");
        // basic set/clear and hold
        step(0, 1, 1, 1, 1, "R2");
        for (int i = 0; i < 3; i++) step(0, 0, 1, 1, 1, "R2");
        step(1, 0, 1, 1, 1, "R2");
        step(0, 0, 1, 1, 1, "R2");
        step(0, 1, 1, 1, 1, "R2");
        // exactly W quiet cycles: no expiry
        for (int i = 0; i < W; i++) step(0, 0, 1, 1, 1, "R4");
        step(0, 1, 1, 1, 1, "R4");
        // W+1 quiet cycles: expiry on the last
        for (int i = 0; i < W + 1; i++) step(0, 0, 1, 1, 1, "R4");
        step(0, 0, 1, 1, 1, "R5");
        // revival by clear pulse, then set
        step(0, 1, 1, 1, 1, "R5");
        step(1, 0, 1, 1, 1, "R5");
        step(0, 1, 1, 1, 1, "R5");
        // double pulse ignored and not treated as activity
        for (int i = 0; i < 5; i++) step(0, 0, 1, 1, 1, "R3");
        step(1, 1, 1, 1, 1, "R3");
        for (int i = 0; i < W; i++) step(0, 0, 1, 1, 1, "R3");
        // enable off / on, pulses while disabled
        step(0, 1, 1, 1, 1, "R6");
        step(0, 0, 0, 1, 1, "R6");
        step(1, 0, 0, 1, 1, "R7");
        step(0, 0, 0, 1, 1, "R7");
        step(0, 0, 1, 1, 1, "R7");
        step(0, 1, 1, 1, 1, "R6");
        // power loss and return
        step(0, 0, 1, 0, 1, "R8");
        step(0, 1, 1, 0, 1, "R8");
        step(0, 0, 1, 1, 1, "R8");
        step(0, 1, 1, 1, 1, "R8");
        // periodic refresh shorter than the limit
        for (int r = 0; r < 10; r++) begin
            step(0, 1, 1, 1, 1, "R9");
            for (int i = 0; i < W / 2 - 1; i++) step(0, 0, 1, 1, 1, "R9");
        end
        step(0, 0, 1, 1, 0, "end");
        @(posedge clk);
        #4;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule